// File: doc/BRIEF.md
# Serial-Programmed Clock Synthesizer Register Interface

This block is the digital front end of a two-output programmable clock generator: one output for video, one for memory. A host programs it over two wires that double as the video-source select pair when no programming is under way. Each 24-bit command word carries a 3-bit register address in its top bits and a 21-bit payload below it. A receiver that runs on a fast system clock recovers the words and writes them into a bank of six registers. The bank holds three video frequency words, a memory frequency word, a power-down word and a control word. The synthesizer itself is not part of this block. The PLL fields are only stored and exposed.

Each word is preceded by an unlock run of clock pulses with the data line high, and then by a start bit. Every payload bit is sent twice, first inverted and then true, so that wiring glitches or a confused host are caught. Such faults pull an active-low error output low. Two strap inputs pick one of four power-on preset sets. The block also decodes the select pair and an internal-clock pin into a video-source code. That code accounts for the "off" and "follow memory clock" index codes held in the video registers.

Top module: `clksyn_serial_regs`

## Requirements
- R1: On reset each frequency word takes a preset. Field layout: bits 6:0 hold Q-2, bits 9:7 hold the post divider M, bits 16:10 hold P-3, bits 20:17 hold the range index. The named presets are Fa=(index 12,P 88,Q 25,M 2), Fb=(12,87,22,2), Fc=(8,95,34,1), Fd=(12,88,25,1), Fe=(5,59,26,1) and Ff=(12,87,22,1). The strap value {boot_a,boot_b} selects the set for memory/video0/video1/video2: 0 gives Fe/Fa/Fb/Fb, 1 gives Fc/Fa/Fb/Fb, 2 gives Fd/Fc/Fb/Fb, 3 gives Ff/Fc/Fd/Fd. The error output is high after reset.
- R2: On reset the power-down word holds code 8 in bits 20:17 and zero elsewhere, and the control word is all zero.
- R3: A framed word of exactly 24 bits, sent least significant bit first, writes its bits 20:0 into the register named by bits 23:21. Address 0, 1 and 2 name the video registers, 3 names memory, 4 names power-down and 6 names control. No other register changes.
- R4: A frame opens with at least 5 serial-clock rising edges that see data high, followed by a start bit. The start bit keeps data low through a rise, a fall and a rise. With only 4 such edges the word is ignored and no register changes.
- R5: Each payload bit is sampled on the falling edge as the inverse value and on the next rising edge as the true value. If both samples are low, the error output goes low and nothing is written. Both samples high mark the stop bit.
- R6: A stop bit after any bit count other than 24 drives the error output low, and nothing is written.
- R7: A stop bit on a word addressed 5 or 7 drives the error output low, and nothing is written.
- R8: Once low, the error output stays low through later activity. It returns high on the 5th consecutive data-high rising edge of a new unlock run.
- R9: The video-source code follows the select pair, with the serial clock line as bit 0 and the data line as bit 1. Pair 0 gives code 0 (video 0), 1 gives code 1 (video 1), 3 gives code 2 (video 2). Pair 2 gives code 3 (feature clock) when the internal-clock pin is low and code 2 when it is high.
- R10: When the chosen video register has index 14 the code becomes 4 (off), and with index 15 it becomes 5 (follow memory clock). The feature-clock choice is not affected.
- R11: The divisor output is 34 minus twice the power-down code (bits 20:17), giving 32 down to 4 for codes 1 to 15 and 18 for code 8. Code 0 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset, loads the strap presets |
| ser_clk_sel0 | input | 1 | Serial clock, also select bit 0 |
| ser_dat_sel1 | input | 1 | Serial data, also select bit 1 |
| boot_a | input | 1 | Preset strap, high bit of the set number |
| boot_b | input | 1 | Preset strap, low bit of the set number |
| int_clk_sel | input | 1 | Internal-clock pin for select pair 2 |
| vid0_word | output | 21 | Video register 0 |
| vid1_word | output | 21 | Video register 1 |
| vid2_word | output | 21 | Video register 2 |
| mem_word | output | 21 | Memory register |
| pdn_word | output | 21 | Power-down register |
| ctl_word | output | 21 | Control register |
| pdn_divisor | output | 6 | Decoded power-down divisor |
| vsrc | output | 3 | Video-source code |
| err_n | output | 1 | Active-low protocol error flag |

## Verification
A receiver that drifts out of step with the serial edges shows up right at the stop bit. Either a word lands in the wrong register, which the full register readout catches after every frame, or the error output drops a few system cycles after the offending edge. A wrong bit count or a payload bit in the wrong position shows as a mismatch in the addressed register after one frame. A bad preset or select decode is visible on the register or source outputs within three system cycles of reset release or of a line change.

// File: rtl/clksyn_pkg.sv
package clksyn_pkg;
  localparam int WORD_W = 24;
  localparam int ADDR_W = 3;
  localparam int DATA_W = WORD_W - ADDR_W;
  localparam int NREG   = 6;
  localparam int IDX_LSB = 17;
  localparam int IDX_W   = 4;
  localparam logic [IDX_W-1:0] PDN_RST_CODE = 4'd8;
  localparam logic [IDX_W-1:0] IDX_OFF  = 4'd14;
  localparam logic [IDX_W-1:0] IDX_MCLK = 4'd15;

  typedef enum logic [2:0] {
    VS_REG0 = 3'd0, VS_REG1 = 3'd1, VS_REG2 = 3'd2,
    VS_FEAT = 3'd3, VS_OFF  = 3'd4, VS_MCLK = 3'd5
  } vsrc_e;

  // register addresses 5 and 7 are unused
  function automatic logic addr_ok(input logic [ADDR_W-1:0] a);
    return (a != 3'd5) && (a != 3'd7);
  endfunction

  // slot number in the bank to its register address
  function automatic logic [ADDR_W-1:0] slot_addr(input int slot);
    return (slot == NREG - 1) ? 3'd6 : ADDR_W'(slot);
  endfunction

  function automatic logic [DATA_W-1:0] pll_word(input int idx, input int p,
                                                 input int q, input int m);
    logic [DATA_W-1:0] w;
    w = '0;
    w[6:0]   = 7'(q - 2);
    w[9:7]   = 3'(m);
    w[16:10] = 7'(p - 3);
    w[20:17] = 4'(idx);
    return w;
  endfunction

  // which: 0..2 video registers, 3 memory register
  function automatic logic [DATA_W-1:0] preset(input logic [1:0] boot, input int which);
    logic [DATA_W-1:0] fa, fb, fc, fd, fe, ff, r;
    fa = pll_word(12, 88, 25, 2);
    fb = pll_word(12, 87, 22, 2);
    fc = pll_word(8, 95, 34, 1);
    fd = pll_word(12, 88, 25, 1);
    fe = pll_word(5, 59, 26, 1);
    ff = pll_word(12, 87, 22, 1);
    case (which)
      0:       r = boot[1] ? fc : fa;
      1, 2:    r = (boot == 2'd3) ? fd : fb;
      default: begin
        case (boot)
          2'd0:    r = fe;
          2'd1:    r = fc;
          2'd2:    r = fd;
          default: r = ff;
        endcase
      end
    endcase
    return r;
  endfunction

  function automatic logic [5:0] pdn_div(input logic [IDX_W-1:0] code);
    return (code == '0) ? 6'd0 : 6'(34 - 2 * int'(code));
  endfunction

  function automatic vsrc_e pick_source(input logic [1:0] sel, input logic intclk,
                                        input logic [IDX_W-1:0] i0,
                                        input logic [IDX_W-1:0] i1,
                                        input logic [IDX_W-1:0] i2);
    vsrc_e s;
    logic [IDX_W-1:0] idx;
    case (sel)
      2'b00:   s = VS_REG0;
      2'b01:   s = VS_REG1;
      2'b11:   s = VS_REG2;
      default: s = intclk ? VS_REG2 : VS_FEAT;
    endcase
    idx = (s == VS_REG0) ? i0 : ((s == VS_REG1) ? i1 : i2);
    if (s != VS_FEAT) begin
      if (idx == IDX_OFF)       s = VS_OFF;
      else if (idx == IDX_MCLK) s = VS_MCLK;
    end
    return s;
  endfunction
endpackage

// File: rtl/clksyn_sync.sv
module clksyn_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_async,
  output logic [N-1:0] d_sync
);
  logic [N-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_async;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/clksyn_rx.sv
module clksyn_rx
  import clksyn_pkg::*;
#(
  parameter int PRE_MIN = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sdat,
  output logic              rise_ev,
  output logic              fall_ev,
  output logic              commit,
  output logic [WORD_W-1:0] word,
  output logic              err_n
);
  localparam int PC_W  = $clog2(PRE_MIN + 1);
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [PC_W-1:0]  PRE_TOP  = PC_W'(PRE_MIN);
  localparam logic [PC_W-1:0]  PRE_LAST = PC_W'(PRE_MIN - 1);
  localparam logic [CNT_W-1:0] NB_FULL  = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] NB_SAT   = CNT_W'(WORD_W + 1);

  typedef enum logic [2:0] {ST_HUNT, ST_STA_F, ST_STA_R, ST_BIT_F, ST_BIT_R} st_e;

  st_e              st, st_n;
  logic             sclk_q, inv_q;
  logic [PC_W-1:0]  pre_cnt;
  logic [CNT_W-1:0] nbits;
  logic [WORD_W-1:0] shreg;
  logic             fail, done, shift;

  assign rise_ev = sclk & ~sclk_q;
  assign fall_ev = ~sclk & sclk_q;
  assign word    = shreg;

  always_comb begin
    st_n  = st;
    fail  = 1'b0;
    done  = 1'b0;
    shift = 1'b0;
    case (st)
      ST_HUNT:  if (rise_ev && !sdat && pre_cnt == PRE_TOP) st_n = ST_STA_F;
      ST_STA_F: if (fall_ev) begin
                  if (sdat) fail = 1'b1;
                  else      st_n = ST_STA_R;
                end
      ST_STA_R: if (rise_ev) begin
                  if (sdat) fail = 1'b1;
                  else      st_n = ST_BIT_F;
                end
      ST_BIT_F: if (fall_ev) st_n = ST_BIT_R;
      ST_BIT_R: if (rise_ev) begin
                  if (inv_q && sdat) begin
                    if (nbits == NB_FULL && addr_ok(shreg[WORD_W-1 -: ADDR_W])) done = 1'b1;
                    else fail = 1'b1;
                  end else if (sdat != inv_q) begin
                    shift = 1'b1;
                    st_n  = ST_BIT_F;
                  end else begin
                    fail = 1'b1;
                  end
                end
      default:  st_n = ST_HUNT;
    endcase
    if (fail || done) st_n = ST_HUNT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_HUNT;
      sclk_q  <= 1'b0;
      inv_q   <= 1'b0;
      pre_cnt <= '0;
      nbits   <= '0;
      shreg   <= '0;
      commit  <= 1'b0;
      err_n   <= 1'b1;
    end else begin
      st     <= st_n;
      sclk_q <= sclk;
      commit <= done;
      if (st == ST_HUNT && rise_ev)
        pre_cnt <= !sdat ? '0 : ((pre_cnt == PRE_TOP) ? PRE_TOP : pre_cnt + 1'b1);
      else if (st != ST_HUNT)
        pre_cnt <= '0;
      if (st == ST_BIT_F && fall_ev) inv_q <= sdat;
      if (st != ST_BIT_F && st != ST_BIT_R) nbits <= '0;
      else if (shift && nbits != NB_SAT)    nbits <= nbits + 1'b1;
      if (shift) shreg <= {sdat, shreg[WORD_W-1:1]};
      if (fail)
        err_n <= 1'b0;
      else if (st == ST_HUNT && rise_ev && sdat && pre_cnt >= PRE_LAST)
        err_n <= 1'b1;
    end
  end
endmodule

// File: rtl/clksyn_regs.sv
module clksyn_regs
  import clksyn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        boot,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  output logic [DATA_W-1:0] bank [NREG]
);
  logic [ADDR_W-1:0] wr_addr;
  assign wr_addr = wr_word[WORD_W-1 -: ADDR_W];

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    localparam logic [ADDR_W-1:0] MY_ADDR = slot_addr(g);
    logic [DATA_W-1:0] rst_val;
    if (g < 4) begin : g_freq
      assign rst_val = preset(boot, (g == 3) ? 3 : g);
    end else if (g == 4) begin : g_pdn
      assign rst_val = DATA_W'(PDN_RST_CODE) << IDX_LSB;
    end else begin : g_ctl
      assign rst_val = '0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)                        bank[g] <= rst_val;
      else if (wr_en && wr_addr == MY_ADDR) bank[g] <= wr_word[DATA_W-1:0];
    end
  end
endmodule

// File: rtl/clksyn_vsel.sv
module clksyn_vsel
  import clksyn_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       sel,
  input  logic             intclk,
  input  logic [IDX_W-1:0] idx0,
  input  logic [IDX_W-1:0] idx1,
  input  logic [IDX_W-1:0] idx2,
  output logic [2:0]       src_code
);
  vsrc_e src_q;

  always_ff @(posedge clk) begin
    if (!rst_n) src_q <= VS_REG0;
    else        src_q <= pick_source(sel, intclk, idx0, idx1, idx2);
  end

  assign src_code = src_q;
endmodule

// File: rtl/clksyn_serial_regs.sv
module clksyn_serial_regs
  import clksyn_pkg::*;
#(
  parameter int PRE_MIN     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk_sel0,
  input  logic              ser_dat_sel1,
  input  logic              boot_a,
  input  logic              boot_b,
  input  logic              int_clk_sel,
  output logic [DATA_W-1:0] vid0_word,
  output logic [DATA_W-1:0] vid1_word,
  output logic [DATA_W-1:0] vid2_word,
  output logic [DATA_W-1:0] mem_word,
  output logic [DATA_W-1:0] pdn_word,
  output logic [DATA_W-1:0] ctl_word,
  output logic [5:0]        pdn_divisor,
  output logic [2:0]        vsrc,
  output logic              err_n
);
  logic [2:0]        line_s;
  logic              rx_rise, rx_fall, wr_commit;
  logic [WORD_W-1:0] wr_word;
  logic [DATA_W-1:0] bank [NREG];

  clksyn_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({int_clk_sel, ser_dat_sel1, ser_clk_sel0}),
    .d_sync  (line_s)
  );

  clksyn_rx #(.PRE_MIN(PRE_MIN)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk    (line_s[0]),
    .sdat    (line_s[1]),
    .rise_ev (rx_rise),
    .fall_ev (rx_fall),
    .commit  (wr_commit),
    .word    (wr_word),
    .err_n   (err_n)
  );

  clksyn_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .boot    ({boot_a, boot_b}),
    .wr_en   (wr_commit),
    .wr_word (wr_word),
    .bank    (bank)
  );

  clksyn_vsel u_vsel (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (line_s[1:0]),
    .intclk   (line_s[2]),
    .idx0     (bank[0][IDX_LSB +: IDX_W]),
    .idx1     (bank[1][IDX_LSB +: IDX_W]),
    .idx2     (bank[2][IDX_LSB +: IDX_W]),
    .src_code (vsrc)
  );

  assign vid0_word   = bank[0];
  assign vid1_word   = bank[1];
  assign vid2_word   = bank[2];
  assign mem_word    = bank[3];
  assign pdn_word    = bank[4];
  assign ctl_word    = bank[5];
  assign pdn_divisor = pdn_div(bank[4][IDX_LSB +: IDX_W]);
endmodule

// File: rtl/clksyn_chk.sv
module clksyn_chk
  import clksyn_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              rise_ev,
  input logic              fall_ev,
  input logic              commit,
  input logic [ADDR_W-1:0] commit_addr,
  input logic              err_n,
  input logic [2:0]        vsrc,
  input logic [DATA_W-1:0] mem_word,
  input logic [IDX_W-1:0]  pdn_code,
  input logic [5:0]        pdn_divisor
);
  a_r7_commit_valid_addr: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (commit_addr != 3'd5 && commit_addr != 3'd7));

  a_r3_commit_without_error: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> err_n);

  a_r5_error_follows_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_n) |-> $past(rise_ev || fall_ev));

  a_r8_error_clears_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_n) |-> $past(rise_ev));

  a_r3_mem_written_by_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_word) |-> $past(commit));

  a_r9_source_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    vsrc <= 3'd5);

  a_r11_divisor_even_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (pdn_code != '0) |-> (pdn_divisor >= 6'd4 && pdn_divisor <= 6'd32 && !pdn_divisor[0]));
endmodule

bind clksyn_serial_regs clksyn_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rise_ev     (rx_rise),
  .fall_ev     (rx_fall),
  .commit      (wr_commit),
  .commit_addr (wr_word[23:21]),
  .err_n       (err_n),
  .vsrc        (vsrc),
  .mem_word    (mem_word),
  .pdn_code    (pdn_word[20:17]),
  .pdn_divisor (pdn_divisor)
);

// File: tb/clksyn_serial_regs_tb.sv
module clksyn_serial_regs_tb;
  localparam int HOLD = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sc = 1'b0, sd = 1'b0, ba = 1'b0, bb = 1'b0, ic = 1'b0;
  logic [20:0] v0, v1, v2, mw, pw, cw;
  logic [5:0]  div;
  logic [2:0]  src;
  logic        errn;

  int n_chk = 0, n_bad = 0;
  logic [20:0] exp_r [6];

  always #2 clk = ~clk;

  clksyn_serial_regs u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk_sel0(sc), .ser_dat_sel1(sd),
    .boot_a(ba), .boot_b(bb), .int_clk_sel(ic),
    .vid0_word(v0), .vid1_word(v1), .vid2_word(v2), .mem_word(mw),
    .pdn_word(pw), .ctl_word(cw), .pdn_divisor(div), .vsrc(src), .err_n(errn)
  );

  function automatic logic [20:0] fw(int idx, int p, int q, int m);
    return {4'(idx), 7'(p - 3), 3'(m), 7'(q - 2)};
  endfunction

  function automatic logic [20:0] exp_preset(int set, int slot);
    logic [20:0] ta [4], tb [4], tc [4], td [4];
    ta = '{fw(12,88,25,2), fw(12,88,25,2), fw(8,95,34,1), fw(8,95,34,1)};
    tb = '{fw(12,87,22,2), fw(12,87,22,2), fw(12,87,22,2), fw(12,88,25,1)};
    tc = '{fw(5,59,26,1), fw(8,95,34,1), fw(12,88,25,1), fw(12,87,22,1)};
    case (slot)
      0:       return ta[set];
      1, 2:    return tb[set];
      3:       return tc[set];
      4:       return 21'd8 << 17;
      default: return 21'd0;
    endcase
    td[0] = '0;
  endfunction

  function automatic int exp_div(logic [20:0] w);
    int code;
    code = int'(w[20:17]);
    return (code == 0) ? 0 : 32 - 2 * (code - 1);
  endfunction

  function automatic int exp_src(logic clk_line, logic dat_line, logic pin);
    int r;
    logic [3:0] idx;
    if (!dat_line) r = clk_line ? 1 : 0;
    else if (clk_line) r = 2;
    else r = pin ? 2 : 3;
    if (r < 3) begin
      idx = exp_r[r][20:17];
      if (idx == 4'd14) r = 4;
      else if (idx == 4'd15) r = 5;
    end
    return r;
  endfunction

  function automatic logic [20:0] act_reg(int s);
    case (s)
      0: return v0; 1: return v1; 2: return v2;
      3: return mw; 4: return pw; default: return cw;
    endcase
  endfunction

  task automatic chk(string tag, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic check_all(string tag);
    for (int s = 0; s < 6; s++) chk(tag, int'(act_reg(s)), int'(exp_r[s]));
    chk({tag, " R11 divisor"}, int'(div), exp_div(exp_r[4]));
  endtask

  task automatic step(logic c, logic d);
    sc = c; sd = d;
    repeat (HOLD) @(posedge clk);
    #1;
  endtask

  // bad_idx >= 0 aborts the word after a bit whose both halves are low
  task automatic send(int pre, logic [31:0] w, int nbits, int bad_idx);
    step(1'b0, 1'b1);
    repeat (pre) begin step(1'b1, 1'b1); step(1'b0, 1'b1); end
    step(1'b0, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b1, 1'b0);
    for (int i = 0; i < nbits; i++) begin
      logic b;
      b = w[i];
      if (i == bad_idx) begin
        step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0); step(1'b1, 1'b0);
        repeat (4) @(posedge clk);
        #1;
        return;
      end
      step(1'b1, ~b); step(1'b0, ~b); step(1'b0, b); step(1'b1, b);
    end
    step(1'b1, 1'b1); step(1'b0, 1'b1); step(1'b1, 1'b1);
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic write_ok(int a, logic [20:0] d);
    send(6, {8'h0, 3'(a), d}, 24, -1);
    exp_r[(a == 6) ? 5 : a] = d;
  endtask

  task automatic do_reset(logic a, logic b);
    sc = 1'b0; sd = 1'b0; ic = 1'b0; ba = a; bb = b; rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    for (int s = 0; s < 6; s++) exp_r[s] = exp_preset({30'd0, a, b}, s);
  endtask

  task automatic vs(logic c, logic d, logic i, string tag);
    sc = c; sd = d; ic = i;
    repeat (8) @(posedge clk);
    #1;
    chk(tag, int'(src), exp_src(c, d, i));
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int lst [6];
    lst = '{0, 1, 2, 3, 4, 6};
    void'($urandom(32'd2024));
    @(posedge clk);
    #1;

    // R1 R2: presets for every strap setting
    for (int st = 0; st < 4; st++) begin
      do_reset(st[1], st[0]);
      check_all("R1 R2 reset");
      chk("R1 err_n after reset", int'(errn), 1);
      chk("R11 reset divisor", int'(div), 18);
    end

    do_reset(1'b1, 1'b0);
    // R3: each address once
    write_ok(0, 21'h0ABCDE); write_ok(1, 21'h13579B); write_ok(2, 21'h02468A);
    write_ok(3, 21'h1FFFFF); write_ok(4, 21'h060000); write_ok(6, 21'h107000);
    check_all("R3 directed");
    chk("R3 err_n", int'(errn), 1);

    // R11: divisor extremes
    write_ok(4, 21'd1 << 17);  chk("R11 code1", int'(div), 32);
    write_ok(4, 21'd15 << 17); chk("R11 code15", int'(div), 4);
    write_ok(4, 21'h01FFFF);   chk("R11 code0", int'(div), 0);

    // R3: random words, minimum preamble
    for (int k = 0; k < 24; k++) begin
      int a;
      logic [20:0] d;
      a = lst[$urandom_range(0, 5)];
      d = 21'($urandom());
      send(5, {8'h0, 3'(a), d}, 24, -1);
      exp_r[(a == 6) ? 5 : a] = d;
      check_all("R3 random");
    end

    // R4: short preamble is ignored
    send(4, {8'h0, 3'd3, 21'h0AAAAA}, 24, -1);
    check_all("R4 short preamble");
    chk("R4 err_n", int'(errn), 1);

    // R5: inverse/true mismatch
    send(6, {8'h0, 3'd1, 21'h055555}, 24, 7);
    chk("R5 err_n", int'(errn), 0);
    check_all("R5 no write");

    // R8: stays low through 4 rises, clears on the 5th
    step(1'b0, 1'b1);
    repeat (4) begin step(1'b1, 1'b1); step(1'b0, 1'b1); end
    chk("R8 still low", int'(errn), 0);
    step(1'b1, 1'b1);
    chk("R8 cleared", int'(errn), 1);
    step(1'b0, 1'b1);

    // R6: wrong bit counts
    send(6, {8'h0, 3'd0, 21'h011111}, 23, -1);
    chk("R6 23 bits err_n", int'(errn), 0);
    check_all("R6 23 bits no write");
    write_ok(0, 21'h0F0F0F);
    chk("R8 good word after error", int'(errn), 1);
    check_all("R8 good word");
    send(6, {7'h0, 1'b1, 3'd2, 21'h012345}, 25, -1);
    chk("R6 25 bits err_n", int'(errn), 0);
    check_all("R6 25 bits no write");

    // R7: unused addresses
    write_ok(3, 21'h0C0C0C);
    send(6, {8'h0, 3'd5, 21'h1AAAAA}, 24, -1);
    chk("R7 addr5 err_n", int'(errn), 0);
    check_all("R7 addr5 no write");
    write_ok(3, 21'h030303);
    send(6, {8'h0, 3'd7, 21'h155555}, 24, -1);
    chk("R7 addr7 err_n", int'(errn), 0);
    check_all("R7 addr7 no write");

    // R9: select decode with ordinary indices
    write_ok(0, fw(3, 60, 20, 1)); write_ok(1, fw(4, 70, 20, 1)); write_ok(2, fw(5, 80, 20, 1));
    vs(1'b0, 1'b0, 1'b0, "R9 pair0");
    vs(1'b1, 1'b0, 1'b0, "R9 pair1");
    vs(1'b1, 1'b1, 1'b0, "R9 pair3");
    vs(1'b0, 1'b1, 1'b0, "R9 pair2 feature");
    vs(1'b0, 1'b1, 1'b1, "R9 pair2 intclk");

    // R10: index overrides
    write_ok(0, fw(14, 60, 20, 1));
    vs(1'b0, 1'b0, 1'b0, "R10 v0 off");
    vs(1'b1, 1'b0, 1'b0, "R10 v1 plain");
    write_ok(1, fw(15, 70, 20, 1));
    vs(1'b1, 1'b0, 1'b0, "R10 v1 mclk");
    write_ok(2, fw(14, 80, 20, 1));
    vs(1'b1, 1'b1, 1'b0, "R10 v2 off");
    vs(1'b0, 1'b1, 1'b1, "R10 v2 off via intclk");
    vs(1'b0, 1'b1, 1'b0, "R10 feature unaffected");

    finish_run();
  end
endmodule